// File: doc/BRIEF.md
# Multi-Mode Registered Bus Lane Stage

This block is one direction of a registered bus path. It carries a word made of independent 9-bit lanes, each lane being 8 data bits plus a parity bit, which the stage stores without interpreting. One storage element per lane can act as a transparent latch, as an edge-triggered register with its own active-low clock enable, or it can simply hold. A separate drive-enable flag stands in for a three-state output stage. The opposite direction of a bus is a second copy of this block.

The whole design runs on a fast system clock. The bus-side capture clock is treated as a data input. The stage samples it on every system edge and detects its rising edges by comparing it with the value it had one system cycle earlier. Transparency is modelled by a shadow register that loads the input on every system cycle while the latch enable is high. While transparent, the output takes the live input. When the latch enable drops, the output keeps the last value the shadow register loaded.

Top module: `lrs_stage`

## Requirements
- R1: `drive_en` is 1 exactly when `oe_n` is 0, whatever the other inputs are.
- R2: While `le` is 1, `q_out` equals `d_in` in the same cycle, for any `bus_clk` and `ce_n`.
- R3: While `le` is 0 and `ce_n[l]` is 1, lane l of `q_out` (bits `l*9+8 : l*9`) keeps its value, even when `bus_clk` rises.
- R4: While `le` is 0 and `ce_n[l]` is 0, a system edge at which `bus_clk` is 1 and was 0 at the previous system edge loads lane l of `d_in`. The new value is visible on `q_out` after that edge.
- R5: While `le` is 0 and `bus_clk` holds a steady level, high or low, `q_out` does not change.
- R6: After `le` falls, `q_out` shows the `d_in` sampled at the last system edge with `le` high. A fall of `le` while `bus_clk` is high causes no capture.
- R7: Each lane follows only its own bit of `ce_n`. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R8: While the stage is in reset, the stored word is zero, so `q_out` is zero with `le` low. `rst_n` asserts asynchronously and is released through two system clock edges.
- R9: `oe_n` has no effect on storage. A capture made while `drive_en` is 0 appears on `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `bus_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Bus capture clock, sampled on `clk` |
| le | input | 1 | Latch enable; 1 makes the stage transparent |
| ce_n | input | LANES | Active-low capture enable, one bit per lane |
| oe_n | input | 1 | Active-low output enable |
| d_in | input | LANES*9 | Input word |
| q_out | output | LANES*9 | Stored or transparent word |
| drive_en | output | 1 | 1 when the output would be driven |

## Verification
The assertions check the following on every system cycle: the same-cycle transparency, holding while a lane's enable is off or the bus clock is steady, per-lane loading one cycle after a detected rise, the value kept when the latch enable falls, the drive flag, and the zero word in reset. Only the bench scenarios can show certain behaviours. One is that a latch-enable fall with the bus clock high triggers no later capture. Another is that captures made while the output is not driven become visible afterwards. A third is that lanes stay independent under long random runs that mix all the modes.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  localparam int LANE_DATA_W = 8;
  localparam int LANE_W      = LANE_DATA_W + 1;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } lane_mode_e;

  // Transparency dominates; otherwise a detected rise loads when enabled.
  function automatic lane_mode_e pick_mode(input logic le,
                                           input logic ce_n,
                                           input logic rise);
    lane_mode_e m;
    if (le)                m = MODE_PASS;
    else if (!ce_n && rise) m = MODE_CAPTURE;
    else                   m = MODE_HOLD;
    return m;
  endfunction

endpackage

// File: rtl/lrs_rst_sync.sv
module lrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lrs_edge_det.sv
module lrs_edge_det (
  input  logic clk,
  input  logic bus_clk,
  output logic rise
);
  // Sample register tracks the bus clock in every cycle, reset or not,
  // so no false rise appears when reset is released.
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= bus_clk;
  end

  always_comb begin
    rise = bus_clk & ~prev_q;
  end
endmodule

// File: rtl/lrs_lane.sv
module lrs_lane
  import lrs_pkg::*;
#(
  parameter int WIDTH = LANE_W
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             le,
  input  logic             rise,
  input  logic             ce_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  lane_mode_e       mode;
  logic             load_en;
  logic [WIDTH-1:0] store_q;

  always_comb begin
    mode    = pick_mode(le, ce_n, rise);
    load_en = (mode != MODE_HOLD);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      store_q <= '0;
    else if (load_en) store_q <= d;
  end

  always_comb begin
    q = (mode == MODE_PASS) ? d : store_q;
  end
endmodule

// File: rtl/lrs_stage.sv
module lrs_stage
  import lrs_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int RST_STAGE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_clk,
  input  logic                     le,
  input  logic [LANES-1:0]         ce_n,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  d_in,
  output logic [LANES*LANE_W-1:0]  q_out,
  output logic                     drive_en
);
  localparam int WORD_W = LANES * LANE_W;

  logic srst_n;
  logic rise;

  lrs_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  lrs_edge_det u_edge (
    .clk     (clk),
    .bus_clk (bus_clk),
    .rise    (rise)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lrs_lane #(.WIDTH(LANE_W)) u_lane (
      .clk    (clk),
      .srst_n (srst_n),
      .le     (le),
      .rise   (rise),
      .ce_n   (ce_n[l]),
      .d      (d_in[l*LANE_W +: LANE_W]),
      .q      (q_out[l*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    drive_en = ~oe_n;
  end

  logic [WORD_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/lrs_stage_chk.sv
module lrs_stage_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input logic                     clk,
  input logic                     srst_n,
  input logic                     bus_clk,
  input logic                     le,
  input logic [LANES-1:0]         ce_n,
  input logic                     oe_n,
  input logic [LANES*LANE_W-1:0]  d_in,
  input logic [LANES*LANE_W-1:0]  q_out,
  input logic                     drive_en
);
  assert_drive_off_R1: assert property (@(posedge clk) oe_n |-> !drive_en);
  assert_drive_on_R1:  assert property (@(posedge clk) !oe_n |-> drive_en);

  assert_pass_R2: assert property (@(posedge clk) disable iff (!srst_n)
    le |-> (q_out == d_in));

  assert_steady_clk_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!le && $stable(bus_clk)) ##1 !le |-> $stable(q_out));

  assert_le_fall_R6: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(le) && $past(srst_n) && !le) |-> (q_out == $past(d_in)));

  assert_reset_zero_R8: assert property (@(posedge clk)
    (!srst_n && !le) |-> (q_out == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!srst_n)
      (!le && ce_n[l]) ##1 !le |-> $stable(q_out[l*LANE_W +: LANE_W]));

    assert_lane_capture_R4: assert property (@(posedge clk) disable iff (!srst_n)
      (!le && !ce_n[l] && bus_clk && !$past(bus_clk)) ##1 !le
        |-> (q_out[l*LANE_W +: LANE_W] == $past(d_in[l*LANE_W +: LANE_W])));
  end
endmodule

bind lrs_stage lrs_stage_chk #(.LANES(LANES), .LANE_W(lrs_pkg::LANE_W)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .bus_clk  (bus_clk),
  .le       (le),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .d_in     (d_in),
  .q_out    (q_out),
  .drive_en (drive_en)
);

// File: tb/tb_lrs_stage.sv
module tb_lrs_stage;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 2;
  localparam int LW     = 9;
  localparam int WW     = LANES * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_clk;
  logic          le;
  logic [LANES-1:0] ce_n;
  logic          oe_n;
  logic [WW-1:0] d_in;
  logic [WW-1:0] q_out;
  logic          drive_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [WW-1:0] m_store;
  logic          m_prev;
  bit            done = 0;

  lrs_stage dut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .le(le), .ce_n(ce_n),
    .oe_n(oe_n), .d_in(d_in), .q_out(q_out), .drive_en(drive_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WW-1:0] exp_q(input logic l, input logic [WW-1:0] d,
                                          input logic [WW-1:0] st);
    return l ? d : st;
  endfunction

  function automatic logic [WW-1:0] next_store(input logic l, input logic bc,
      input logic pv, input logic [LANES-1:0] ce, input logic [WW-1:0] d,
      input logic [WW-1:0] st);
    logic [WW-1:0] r;
    r = st;
    for (int k = 0; k < LANES; k++) begin
      if (l || (!ce[k] && bc && !pv)) r[k*LW +: LW] = d[k*LW +: LW];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // Drive at the falling edge, check, then let one system edge pass.
  task automatic cyc(input logic l, input logic bc, input logic [LANES-1:0] ce,
                     input logic [WW-1:0] d, input logic oe, input string tag);
    le = l; bus_clk = bc; ce_n = ce; d_in = d; oe_n = oe;
    #1;
    check(tag, q_out, exp_q(l, d, m_store));
    check("R1", {{(WW-1){1'b0}}, drive_en}, {{(WW-1){1'b0}}, ~oe});
    @(posedge clk);
    m_store = next_store(l, bc, m_prev, ce, d, m_store);
    m_prev  = bc;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_clk = 1'b0; le = 1'b0; ce_n = '1; oe_n = 1'b1; d_in = '0;
    m_store = '0; m_prev = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", q_out, '0);
    check("R1", {{(WW-1){1'b0}}, drive_en}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", q_out, '0);

    // R2: transparency regardless of clock and enables
    cyc(1, 0, 2'b11, 18'h2A5A5, 0, "R2");
    cyc(1, 1, 2'b00, 18'h15A5A, 0, "R2");
    // R6: fall of le with bus clock high keeps last transparent word, no capture
    cyc(1, 1, 2'b00, 18'h12345, 0, "R2");
    cyc(0, 1, 2'b00, 18'h3FFFF, 0, "R6");
    cyc(0, 1, 2'b00, 18'h3FFFF, 0, "R6");
    // R5: steady high then steady low
    cyc(0, 1, 2'b00, 18'h00001, 0, "R5");
    cyc(0, 0, 2'b00, 18'h00002, 0, "R5");
    cyc(0, 0, 2'b00, 18'h00003, 0, "R5");
    // R4: rise with both lanes enabled
    cyc(0, 1, 2'b00, 18'h2BEEF, 0, "R4");
    cyc(0, 1, 2'b00, 18'h00000, 0, "R4");
    // R6: fall of le with bus clock low
    cyc(1, 0, 2'b11, 18'h1C3C3, 0, "R2");
    cyc(0, 0, 2'b11, 18'h00F0F, 0, "R6");
    // R3: both lanes disabled ignore a rise
    cyc(0, 1, 2'b11, 18'h3AAAA, 0, "R3");
    cyc(0, 0, 2'b11, 18'h3AAAA, 0, "R3");
    // R7: only lane 0 enabled, then only lane 1
    cyc(0, 1, 2'b10, 18'h3FFFF, 0, "R7");
    cyc(0, 0, 2'b01, 18'h00000, 0, "R7");
    cyc(0, 1, 2'b01, 18'h00000, 0, "R7");
    cyc(0, 0, 2'b11, 18'h11111, 0, "R7");
    // R9: capture while not driven, then observe
    cyc(0, 1, 2'b00, 18'h0ABCD, 1, "R9");
    cyc(0, 1, 2'b11, 18'h00000, 1, "R9");
    cyc(0, 0, 2'b11, 18'h00000, 0, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic          rl, rb, ro;
      logic [1:0]    rc;
      logic [WW-1:0] rd;
      string         tg;
      rl = ($urandom % 4) == 0;
      rb = $urandom % 2;
      rc = $urandom % 4;
      ro = $urandom % 2;
      rd = $urandom;
      if (rl)                 tg = "R2";
      else if (rb && !m_prev) tg = "R4";
      else                    tg = "R5";
      cyc(rl, rb, rc, rd, ro, tg);
    end

    // R8: asynchronous reset mid-run clears the word
    rst_n = 1'b0; le = 1'b0;
    #1;
    check("R8", q_out, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule